// File: doc/BRIEF.md
# RISC Integer Decode and Execute Stage

This block takes one 32-bit instruction word of a three-operand RISC integer subset, together with the two source register values already read for it. It decodes the word, forms the second operand (register or extended immediate), computes the result, and reports where that result should go. Everything is captured in an output register, so results appear one clock after the inputs are sampled.

Register-register instructions (opcode 0) choose their operation by function code and write the register named in bits 15:11. Immediate instructions carry a 16-bit constant in bits 15:0 and write the register named in bits 20:16. For loads and stores the result is the effective address, and an address-valid flag goes high. The register file, data memory and program counter sit outside this block.

Encodings the block does not know raise an illegal flag and produce no write. Writes aimed at register 0 are dropped, because that register always reads as zero.

Top module: `rx_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge. Otherwise each output reflects the inputs sampled at the previous rising edge.
- R2: The word splits into opcode 31:26, rs 25:21, rt 20:16, rd 15:11, shift 10:6 and function 5:0. Opcode 0 with function 32 gives rs+rt written to rd, so 0x00AF8020 writes register 16.
- R3: With opcode 0, function 34 gives rs-rt, 36 gives rs AND rt, 37 gives rs OR rt, and 39 gives NOT(rs OR rt).
- R4: With opcode 0, function 42 writes 1 when rs < rt as signed two's complement numbers and 0 otherwise. `lt_o` equals that bit, and this holds even when rs-rt would overflow.
- R5: With opcode 0, function 0 shifts rt left and function 2 shifts rt right (logical), by the amount in bits 10:6 (0 to 31). The result goes to rd.
- R6: Opcode 8 gives rs plus the sign-extended immediate. Opcode 10 writes 1 when rs is less than the sign-extended immediate (signed), and `lt_o` follows. Both write rt.
- R7: Opcode 12 gives rs AND the zero-extended immediate, and opcode 13 gives rs OR the zero-extended immediate. Both write rt.
- R8: Opcode 15 places the immediate in bits 31:16 of the result with bits 15:0 zero, written to rt.
- R9: Loads (opcode 32 byte, 35 word) give rs plus the sign-extended offset as the result, raise `addr_valid_o`, and write rt.
- R10: Stores (opcode 40 byte, 43 word) give rs plus the sign-extended offset, raise `addr_valid_o`, and keep `wr_en_o` low.
- R11: `wr_en_o` is never high with destination 0. `dest_o` reads 0 whenever `wr_en_o` is low.
- R12: Any other opcode, or opcode 0 with any other function code, raises `illegal_o` and keeps `wr_en_o`, `addr_valid_o`, `lt_o` and `result_o` at zero.
- R13: `lt_o` is zero for every instruction other than the two set-less-than forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Computed value or effective address |
| dest_o | output | 5 | Destination register index, 0 when no write |
| wr_en_o | output | 1 | Register write enable |
| lt_o | output | 1 | Less-than outcome of a set-less-than |
| addr_valid_o | output | 1 | Result is a memory address (load or store) |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The hardest case is a signed comparison whose difference overflows, for example 0x7FFFFFFF against 0x80000000. A compare built on the sign of rs-rt gives the wrong answer there. Random operands almost never land on such pairs, so the stimulus places these extremes directly into `rs_val_i`/`rt_val_i` and into the sign bit of the immediate. Writes to register 0 and unknown function codes are also driven on purpose. All of these run alongside a long stream of random legal and illegal words, and every cycle is checked against the bench's behavioural model.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int RIDX_W  = 5;
  localparam int SHAMT_W = 5;
  localparam int FUNC_W  = 6;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;
  localparam logic [OPC_W-1:0] OPC_LDB  = 6'd32;
  localparam logic [OPC_W-1:0] OPC_LDW  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STB  = 6'd40;
  localparam logic [OPC_W-1:0] OPC_STW  = 6'd43;

  localparam logic [FUNC_W-1:0] FN_SHL = 6'd0;
  localparam logic [FUNC_W-1:0] FN_SHR = 6'd2;
  localparam logic [FUNC_W-1:0] FN_ADD = 6'd32;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'd34;
  localparam logic [FUNC_W-1:0] FN_AND = 6'd36;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'd37;
  localparam logic [FUNC_W-1:0] FN_NOR = 6'd39;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR, OP_SLT, OP_SHL, OP_SHR, OP_UPPER
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_imm;
    logic    imm_zext;
    logic    dst_rt;
    logic    writes;
    logic    mem;
    logic    illegal;
  } ctrl_t;
endpackage

// File: rtl/rx_decode.sv
module rx_decode
  import rx_pkg::*;
(
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [FUNC_W-1:0] func_i,
  output ctrl_t             ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.op = OP_ADD;
    case (opc_i)
      OPC_REG: begin
        ctrl_o.writes = 1'b1;
        case (func_i)
          FN_ADD:  ctrl_o.op = OP_ADD;
          FN_SUB:  ctrl_o.op = OP_SUB;
          FN_AND:  ctrl_o.op = OP_AND;
          FN_OR:   ctrl_o.op = OP_OR;
          FN_NOR:  ctrl_o.op = OP_NOR;
          FN_SLT:  ctrl_o.op = OP_SLT;
          FN_SHL:  ctrl_o.op = OP_SHL;
          FN_SHR:  ctrl_o.op = OP_SHR;
          default: begin
            ctrl_o.writes  = 1'b0;
            ctrl_o.illegal = 1'b1;
          end
        endcase
      end
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_LUI: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.dst_rt  = 1'b1;
        ctrl_o.writes  = 1'b1;
        case (opc_i)
          OPC_SLTI: ctrl_o.op = OP_SLT;
          OPC_ANDI: begin ctrl_o.op = OP_AND;   ctrl_o.imm_zext = 1'b1; end
          OPC_ORI:  begin ctrl_o.op = OP_OR;    ctrl_o.imm_zext = 1'b1; end
          OPC_LUI:  begin ctrl_o.op = OP_UPPER; ctrl_o.imm_zext = 1'b1; end
          default:  ctrl_o.op = OP_ADD;
        endcase
      end
      OPC_LDB, OPC_LDW: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.dst_rt  = 1'b1;
        ctrl_o.writes  = 1'b1;
        ctrl_o.mem     = 1'b1;
      end
      OPC_STB, OPC_STW: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem     = 1'b1;
      end
      default: ctrl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/rx_alu.sv
module rx_alu
  import rx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = 5,
  parameter int UPPER   = 16
) (
  input  alu_op_e             op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [SHIFT_W-1:0]  shamt_i,
  output logic [DATA_W-1:0]   y_o,
  output logic                lt_o
);
  logic signed_lt;
  assign signed_lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    lt_o = 1'b0;
    case (op_i)
      OP_ADD:   y_o = a_i + b_i;
      OP_SUB:   y_o = a_i - b_i;
      OP_AND:   y_o = a_i & b_i;
      OP_OR:    y_o = a_i | b_i;
      OP_NOR:   y_o = ~(a_i | b_i);
      OP_SLT: begin
        y_o  = {{(DATA_W-1){1'b0}}, signed_lt};
        lt_o = signed_lt;
      end
      OP_SHL:   y_o = b_i << shamt_i;
      OP_SHR:   y_o = b_i >> shamt_i;
      OP_UPPER: y_o = b_i << UPPER;
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
  import rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [DATA_W-1:0]    rs_val_i,
  input  logic [DATA_W-1:0]    rt_val_i,
  output logic [DATA_W-1:0]    result_o,
  output logic [RIDX_W-1:0]    dest_o,
  output logic                 wr_en_o,
  output logic                 lt_o,
  output logic                 addr_valid_o,
  output logic                 illegal_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [OPC_W-1:0]   opc;
  logic [RIDX_W-1:0]  rt_idx, rd_idx, dst_idx;
  logic [SHAMT_W-1:0] shamt;
  logic [FUNC_W-1:0]  func;
  logic [IMM_W-1:0]   imm;
  logic [DATA_W-1:0]  imm_ext, opnd_b, alu_y;
  logic               alu_lt, do_write;
  ctrl_t              ctrl;

  assign opc    = instr_i[31:26];
  assign rt_idx = instr_i[20:16];
  assign rd_idx = instr_i[15:11];
  assign shamt  = instr_i[10:6];
  assign func   = instr_i[5:0];
  assign imm    = instr_i[15:0];

  rx_decode u_dec (
    .opc_i  (opc),
    .func_i (func),
    .ctrl_o (ctrl)
  );

  assign imm_ext  = ctrl.imm_zext ? {{EXT_W{1'b0}}, imm} : {{EXT_W{imm[IMM_W-1]}}, imm};
  assign opnd_b   = ctrl.use_imm ? imm_ext : rt_val_i;
  assign dst_idx  = ctrl.dst_rt ? rt_idx : rd_idx;
  assign do_write = ctrl.writes && (dst_idx != '0);

  rx_alu #(.DATA_W(DATA_W), .SHIFT_W(SHAMT_W), .UPPER(IMM_W)) u_alu (
    .op_i    (ctrl.op),
    .a_i     (rs_val_i),
    .b_i     (opnd_b),
    .shamt_i (shamt),
    .y_o     (alu_y),
    .lt_o    (alu_lt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o     <= '0;
      dest_o       <= '0;
      wr_en_o      <= 1'b0;
      lt_o         <= 1'b0;
      addr_valid_o <= 1'b0;
      illegal_o    <= 1'b0;
    end else begin
      result_o     <= ctrl.illegal ? '0 : alu_y;
      dest_o       <= do_write ? dst_idx : '0;
      wr_en_o      <= do_write;
      lt_o         <= alu_lt && !ctrl.illegal;
      addr_valid_o <= ctrl.mem;
      illegal_o    <= ctrl.illegal;
    end
  end
endmodule

// File: rtl/rx_exec_chk.sv
module rx_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr_i,
  input logic [31:0] result_o,
  input logic [4:0]  dest_o,
  input logic        wr_en_o,
  input logic        lt_o,
  input logic        addr_valid_o,
  input logic        illegal_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wr_en_o && !illegal_o && !addr_valid_o && result_o == 32'd0);

  // R11
  no_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> dest_o != 5'd0);

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wr_en_o && !addr_valid_o && !lt_o && result_o == 32'd0);

  // R4
  lt_means_one_chk: assert property (@(posedge clk) disable iff (rst)
    lt_o |-> result_o == 32'd1);

  // R8
  upper_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(instr_i[31:26] == 6'd15) |-> result_o[15:0] == 16'd0 && !illegal_o);

  // R10
  store_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(instr_i[31:26]) == 6'd40 || $past(instr_i[31:26]) == 6'd43))
      |-> addr_valid_o && !wr_en_o);

  // R12
  write_or_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en_o, illegal_o}));
endmodule

bind rx_exec_unit rx_exec_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .instr_i      (instr_i),
  .result_o     (result_o),
  .dest_o       (dest_o),
  .wr_en_o      (wr_en_o),
  .lt_o         (lt_o),
  .addr_valid_o (addr_valid_o),
  .illegal_o    (illegal_o)
);

// File: tb/test_rx_exec_unit.sv
module test_rx_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] result_o;
  logic [4:0]  dest_o;
  logic        wr_en_o, lt_o, addr_valid_o, illegal_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic        have_exp = 0;
  logic [31:0] e_res;
  logic [4:0]  e_dst;
  logic        e_we, e_lt, e_av, e_il;
  string       e_tag;

  always #5 clk = ~clk;

  rx_exec_unit i_rx_exec_unit (
    .clk(clk), .rst(rst), .instr_i(instr_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .result_o(result_o), .dest_o(dest_o), .wr_en_o(wr_en_o), .lt_o(lt_o),
    .addr_valid_o(addr_valid_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  // Behavioural reference: what each instruction should produce
  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    int op = int'(ins[31:26]);
    int fn = int'(ins[5:0]);
    int sh = int'(ins[10:6]);
    logic [15:0] imm = ins[15:0];
    logic [31:0] se = {{16{imm[15]}}, imm};
    logic [31:0] ze = {16'd0, imm};
    int dst = 0;
    e_res = 0; e_we = 0; e_lt = 0; e_av = 0; e_il = 0;
    if (op == 0) begin
      dst = int'(ins[15:11]);
      e_we = 1;
      case (fn)
        32: begin e_res = a + b; e_tag = "R2"; end
        34: begin e_res = a - b; e_tag = "R3"; end
        36: begin e_res = a & b; e_tag = "R3"; end
        37: begin e_res = a | b; e_tag = "R3"; end
        39: begin e_res = ~(a | b); e_tag = "R3"; end
        42: begin e_lt = $signed(a) < $signed(b); e_res = {31'd0, e_lt}; e_tag = "R4"; end
        0:  begin e_res = b << sh; e_tag = "R5"; end
        2:  begin e_res = b >> sh; e_tag = "R5"; end
        default: begin e_we = 0; e_il = 1; e_tag = "R12"; end
      endcase
    end else begin
      dst = int'(ins[20:16]);
      e_we = 1;
      case (op)
        8:  begin e_res = a + se; e_tag = "R6"; end
        10: begin e_lt = $signed(a) < $signed(se); e_res = {31'd0, e_lt}; e_tag = "R6"; end
        12: begin e_res = a & ze; e_tag = "R7"; end
        13: begin e_res = a | ze; e_tag = "R7"; end
        15: begin e_res = {imm, 16'd0}; e_tag = "R8"; end
        32, 35: begin e_res = a + se; e_av = 1; e_tag = "R9"; end
        40, 43: begin e_res = a + se; e_av = 1; e_we = 0; e_tag = "R10"; end
        default: begin e_we = 0; e_il = 1; e_tag = "R12"; end
      endcase
    end
    if (e_we && dst == 0) begin e_we = 0; e_tag = "R11"; end
    e_dst = e_we ? dst[4:0] : 5'd0;
  endtask

  task automatic compare();
    if (!have_exp) return;
    n_checks++;
    if (result_o !== e_res || dest_o !== e_dst || wr_en_o !== e_we || lt_o !== e_lt ||
        addr_valid_o !== e_av || illegal_o !== e_il) begin
      n_fail++;
      $display("FAIL %s instr=%h: got res=%h dst=%0d we=%b lt=%b av=%b il=%b, expected res=%h dst=%0d we=%b lt=%b av=%b il=%b",
               e_tag, instr_i, result_o, dest_o, wr_en_o, lt_o, addr_valid_o, illegal_o,
               e_res, e_dst, e_we, e_lt, e_av, e_il);
    end
  endtask

  // One cycle: check what the last inputs produced, then apply new ones
  task automatic step(input logic r, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    compare();
    rst = r; instr_i = ins; rs_val_i = a; rt_val_i = b;
    if (r) begin
      e_res = 0; e_dst = 0; e_we = 0; e_lt = 0; e_av = 0; e_il = 0; e_tag = "R1";
    end else begin
      model(ins, a, b);
    end
    have_exp = 1;
  endtask

  initial begin
    // R1: reset clears outputs even with a writing instruction applied
    step(1, enc_r(1, 2, 3, 0, 32), 32'd5, 32'd6);
    step(1, enc_i(15, 0, 4, 16'hFFFF), 32'd0, 32'd0);
    step(1, 32'h00AF8020, 32'd1, 32'd2);
    // R2: the documented add word, rd=16
    step(0, 32'h00AF8020, 32'd100, 32'd23);
    // R3: sub, and, or, nor
    step(0, enc_r(3, 4, 5, 0, 34), 32'd10, 32'd20);
    step(0, enc_r(3, 4, 6, 0, 36), 32'hF0F0_1234, 32'h0FF0_FF00);
    step(0, enc_r(3, 4, 7, 0, 37), 32'hF000_0001, 32'h0000_F0F0);
    step(0, enc_r(3, 4, 8, 0, 39), 32'h0000_0000, 32'h0000_0000);
    // R4: signed compares, including overflowing differences
    step(0, enc_r(1, 2, 9, 0, 42), 32'h7FFF_FFFF, 32'h8000_0000);
    step(0, enc_r(1, 2, 9, 0, 42), 32'h8000_0000, 32'h7FFF_FFFF);
    step(0, enc_r(1, 2, 9, 0, 42), 32'hFFFF_FFFF, 32'd0);
    step(0, enc_r(1, 2, 9, 0, 42), 32'd7, 32'd7);
    // R5: shifts at 0, 4 and 31
    step(0, enc_r(0, 16, 10, 4, 0), 32'd0, 32'h0000_0013);
    step(0, enc_r(0, 16, 10, 31, 0), 32'd0, 32'h0000_0003);
    step(0, enc_r(0, 16, 10, 31, 2), 32'd0, 32'h8000_0000);
    step(0, enc_r(0, 16, 10, 0, 2), 32'd0, 32'hDEAD_BEEF);
    // R6: negative immediate add and signed immediate compare
    step(0, enc_i(8, 1, 11, 16'hFFFC), 32'd2, 32'hAAAA_AAAA);
    step(0, enc_i(10, 1, 11, 16'h8000), 32'hFFFF_0000, 32'd0);
    step(0, enc_i(10, 1, 11, 16'h000A), 32'h8000_0000, 32'd0);
    // R7: zero extension of logical immediates
    step(0, enc_i(12, 1, 12, 16'hFF00), 32'hFFFF_FFFF, 32'd0);
    step(0, enc_i(13, 1, 12, 16'h8001), 32'h1234_0000, 32'd0);
    // R8: upper immediate then or-immediate
    step(0, enc_i(15, 7, 13, 16'hAAAA), 32'hFFFF_FFFF, 32'd0);
    step(0, enc_i(13, 13, 13, 16'hAAAA), 32'hAAAA_0000, 32'd0);
    // R9: word load rs=18 offset 32, byte load negative offset
    step(0, enc_i(35, 18, 8, 16'd32), 32'h0000_1000, 32'd0);
    step(0, enc_i(32, 9, 14, 16'hFFFF), 32'h0000_0100, 32'd0);
    // R10: stores
    step(0, enc_i(43, 9, 8, 16'd1200), 32'h0000_0040, 32'h5555_5555);
    step(0, enc_i(40, 9, 0, 16'hFFF0), 32'h0000_0040, 32'd0);
    // R11: writes to register 0 suppressed
    step(0, enc_r(1, 2, 0, 0, 32), 32'd1, 32'd1);
    step(0, enc_i(35, 1, 0, 16'd4), 32'd8, 32'd0);
    // R12: unknown opcode (2) and unknown function (8)
    step(0, enc_i(2, 1, 3, 16'h1234), 32'd1, 32'd2);
    step(0, enc_r(31, 31, 31, 0, 8), 32'hFFFF_FFFF, 32'd1);
    // R1: reset mid-stream
    step(1, enc_r(1, 2, 3, 0, 42), 32'd0, 32'd1);
    // R13 and broad mix: random words drawn from legal and illegal codes
    for (int k = 0; k < 600; k++) begin
      int pick = $urandom_range(0, 19);
      int ops[10] = '{8, 10, 12, 13, 15, 32, 35, 40, 43, 4};
      int fns[9]  = '{32, 34, 36, 37, 39, 42, 0, 2, 12};
      logic [31:0] w = $urandom;
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      if (pick < 9) w[31:26] = 6'd0;
      if (pick < 9) w[5:0] = fns[pick][5:0];
      else if (pick < 19) w[31:26] = ops[pick-9][5:0];
      if (k % 7 == 0) a = 32'h8000_0000;
      if (k % 11 == 0) b = 32'h7FFF_FFFF;
      step(0, w, a, b);
    end
    step(0, 32'd0, 32'd0, 32'd0);
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule